// File: doc/BRIEF.md
# Five-Input Lookup Logic Cell

This block is one configurable logic cell. A 32-bit truth table is addressed by five logic inputs, so the cell can compute any Boolean function of five variables. A mode bit can split the table into two 16-entry halves instead. Each half then computes its own four-input function, F or G. Three of the inputs to each half are fixed. The fourth input of each half is chosen from the two upper logic inputs or from the outputs of the cell's two flip-flops. Because the flip-flop outputs can feed back into the table, a single cell can build small state machines such as toggles and counters.

Each of the two flip-flops captures either F or G on the rising clock edge. Each of the two outputs, X and Y, is set up on its own. It either passes the combinational value directly or shows its flip-flop's stored value. All configuration, meaning the table contents, the mode, the input selects, the flip-flop sources and the output modes, is loaded through a one-bit serial port while a load strobe is held high. During loading the outputs are forced low and the flip-flops are cleared.

Top module: `clb5_logic_block`

## Requirements
- R1: While `rst_n` is low, the configuration and both flip-flops are cleared. As a result `x_out` and `y_out` read 0 for every value of `lin`.
- R2: When the split bit is 0, F and G are both equal to table entry `lin` (index bit 0 is `lin[0]`, bit 4 is `lin[4]`).
- R3: A table with only entry 31 set makes F a five-input AND: 1 only when `lin` is 5'b11111.
- R4: When the split bit is 1, F is table entry {0, s_f, lin[2:0]} and G is table entry {1, s_g, lin[2:0]}. F therefore uses entries 0 to 15 and G uses entries 16 to 31.
- R5: The fourth-input select codes are 0 = `lin[3]`, 1 = `lin[4]`, 2 = flip-flop X output, 3 = flip-flop Y output. Choosing code 2 with a table that inverts it makes the X flip-flop toggle on every clock.
- R6: On each rising clock edge outside loading, flip-flop X stores G if its source bit is 1 and F otherwise. Flip-flop Y does the same with its own source bit.
- R7: `x_out` shows flip-flop X when its registered bit is 1 and shows F otherwise. `y_out` does the same with flip-flop Y and G.
- R8: Each clock with `cfg_load` high shifts `cfg_sin` into bit 40 and moves every bit down by one place, so after 41 clocks the first bit sent sits in bit 0. The bit layout is: [31:0] table, [32] split, [34:33] F select, [36:35] G select, [37] X source, [38] Y source, [39] X registered, [40] Y registered. The configuration does not change while `cfg_load` is low.
- R9: While `cfg_load` is high, `x_out` and `y_out` are 0, and each clock edge clears both flip-flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Configuration shift enable |
| cfg_sin | input | 1 | Serial configuration data, first bit ends at bit 0 |
| lin | input | LUT_INPUTS (5) | Logic inputs A (bit 0) to E (bit 4) |
| x_out | output | 1 | Output X: F or flip-flop X |
| y_out | output | 1 | Output Y: G or flip-flop Y |

## Verification
Two events can fall in the same cycle: a flip-flop capture with its own output fed back into the table, and the start of a configuration load. The bench provokes this by running a toggling cell with X registered and then raising `cfg_load` in a cycle where the X flip-flop holds 1. A behavioural model, stepped every clock, expects the outputs to be 0 in that cycle and the flip-flop to be cleared rather than toggled once the new setup is in place. The feedback select codes are also tried against a stored state of 1 and of 0, so that a wrong feedback path shows up as a wrong output on the very next clock.

// File: rtl/clb_pkg.sv
package clb_pkg;

   // Source of the fourth input to each table half in split mode
   typedef enum logic [1:0] {
      SEL_LOWER = 2'd0,   // lin[N-2]
      SEL_UPPER = 2'd1,   // lin[N-1]
      SEL_QX    = 2'd2,   // flip-flop X feedback
      SEL_QY    = 2'd3    // flip-flop Y feedback
   } clb_sel_e;

   // Control word stored above the truth table; the last member is the LSB
   typedef struct packed {
      logic       y_reg;
      logic       x_reg;
      logic       qy_g;
      logic       qx_g;
      logic [1:0] g_sel;
      logic [1:0] f_sel;
      logic       split;
   } clb_ctl_t;

   localparam int CTL_W = $bits(clb_ctl_t);

endpackage

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain #(
   parameter int W = 41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         sin,
   output logic [W-1:0] cfg
);

   generate
      if (W < 2) begin : g_bad
         $error("clb_cfg_chain: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= '0;
      else if (load)
         cfg <= {sin, cfg[W-1:1]};
   end

endmodule

// File: rtl/clb_lut.sv
module clb_lut
   import clb_pkg::*;
#(
   parameter int N         = 5,
   parameter bit HAS_SPLIT = 1'b1,
   localparam int L        = 1 << N,
   localparam int H        = N - 1
) (
   input  logic [L-1:0] table_bits,
   input  logic [N-1:0] lin,
   input  logic         split,
   input  logic [1:0]   f_sel,
   input  logic [1:0]   g_sel,
   input  logic         qx,
   input  logic         qy,
   output logic         f,
   output logic         g
);

   logic full_val;
   assign full_val = table_bits[lin];

   generate
      if (HAS_SPLIT) begin : g_split
         logic         f4, g4;
         logic [H-1:0] f_idx, g_idx;

         function automatic logic pick(input logic [1:0] s, input logic [N-1:0] v,
                                       input logic fx, input logic fy);
            case (clb_sel_e'(s))
               SEL_LOWER: pick = v[N-2];
               SEL_UPPER: pick = v[N-1];
               SEL_QX:    pick = fx;
               default:   pick = fy;
            endcase
         endfunction

         assign f4    = pick(f_sel, lin, qx, qy);
         assign g4    = pick(g_sel, lin, qx, qy);
         assign f_idx = {f4, lin[N-3:0]};
         assign g_idx = {g4, lin[N-3:0]};
         assign f     = split ? table_bits[{1'b0, f_idx}] : full_val;
         assign g     = split ? table_bits[{1'b1, g_idx}] : full_val;
      end else begin : g_full
         assign f = full_val;
         assign g = full_val;
      end
   endgenerate

endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic f,
   input  logic g,
   input  logic qx_g,
   input  logic qy_g,
   input  logic x_reg,
   input  logic y_reg,
   output logic qx,
   output logic qy,
   output logic x,
   output logic y
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qx <= 1'b0;
         qy <= 1'b0;
      end else if (load) begin
         qx <= 1'b0;
         qy <= 1'b0;
      end else begin
         qx <= qx_g ? g : f;
         qy <= qy_g ? g : f;
      end
   end

   assign x = load ? 1'b0 : (x_reg ? qx : f);
   assign y = load ? 1'b0 : (y_reg ? qy : g);

endmodule

// File: rtl/clb5_logic_block.sv
module clb5_logic_block
   import clb_pkg::*;
#(
   parameter int LUT_INPUTS = 5,
   parameter bit HAS_SPLIT  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic                  cfg_sin,
   input  logic [LUT_INPUTS-1:0] lin,
   output logic                  x_out,
   output logic                  y_out
);

   localparam int LUT_BITS = 1 << LUT_INPUTS;
   localparam int CFG_W    = LUT_BITS + CTL_W;

   generate
      if (LUT_INPUTS < 3 || LUT_INPUTS > 6) begin : g_bad
         $error("clb5_logic_block: LUT_INPUTS must lie in 3..6");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   clb_ctl_t         ctl;
   logic             f_val, g_val, qx, qy;

   assign ctl = cfg_q[CFG_W-1:LUT_BITS];

   clb_cfg_chain #(.W(CFG_W)) u_chain (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cfg_load),
      .sin  (cfg_sin),
      .cfg  (cfg_q)
   );

   clb_lut #(.N(LUT_INPUTS), .HAS_SPLIT(HAS_SPLIT)) u_lut (
      .table_bits(cfg_q[LUT_BITS-1:0]),
      .lin       (lin),
      .split     (ctl.split),
      .f_sel     (ctl.f_sel),
      .g_sel     (ctl.g_sel),
      .qx        (qx),
      .qy        (qy),
      .f         (f_val),
      .g         (g_val)
   );

   clb_out_stage u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cfg_load),
      .f    (f_val),
      .g    (g_val),
      .qx_g (ctl.qx_g),
      .qy_g (ctl.qy_g),
      .x_reg(ctl.x_reg),
      .y_reg(ctl.y_reg),
      .qx   (qx),
      .qy   (qy),
      .x    (x_out),
      .y    (y_out)
   );

endmodule

// File: rtl/clb5_logic_block_chk.sv
module clb5_logic_block_chk
   import clb_pkg::*;
#(
   parameter int LUT_INPUTS = 5,
   parameter int CFG_W      = 41,
   localparam int LUT_BITS  = 1 << LUT_INPUTS
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cfg_load,
   input logic                  cfg_sin,
   input logic [LUT_INPUTS-1:0] lin,
   input logic                  x_out,
   input logic                  y_out,
   input logic [CFG_W-1:0]      cfg_q,
   input logic                  f_val,
   input logic                  g_val,
   input logic                  qx,
   input logic                  qy
);

   clb_ctl_t ctl;
   logic     qx_want, qy_want;

   assign ctl     = cfg_q[CFG_W-1:LUT_BITS];
   assign qx_want = ctl.qx_g ? g_val : f_val;
   assign qy_want = ctl.qy_g ? g_val : f_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (qx == 1'b0 && qy == 1'b0 && cfg_q == '0)
            else $error("reset did not clear state");
      end
   end

   assert_full_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && !ctl.split && !ctl.x_reg) |-> (x_out == cfg_q[lin]));

   assert_capture_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> (qx == $past(qx_want)));

   assert_capture_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> (qy == $past(qy_want)));

   assert_x_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && ctl.x_reg) |-> (x_out == qx));

   assert_y_registered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_load && ctl.y_reg) |-> (y_out == qy));

   assert_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (cfg_q == {$past(cfg_sin), $past(cfg_q[CFG_W-1:1])}));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(cfg_q));

   assert_load_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |-> (x_out == 1'b0 && y_out == 1'b0));

   assert_load_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (qx == 1'b0 && qy == 1'b0));

endmodule

bind clb5_logic_block clb5_logic_block_chk #(
   .LUT_INPUTS(LUT_INPUTS),
   .CFG_W     (CFG_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_load(cfg_load),
   .cfg_sin (cfg_sin),
   .lin     (lin),
   .x_out   (x_out),
   .y_out   (y_out),
   .cfg_q   (cfg_q),
   .f_val   (f_val),
   .g_val   (g_val),
   .qx      (qx),
   .qy      (qy)
);

// File: tb/clb5_logic_block_test.sv
module clb5_logic_block_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic       cfg_sin = 1'b0;
   logic [4:0] lin = '0;
   logic       x_out, y_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   logic [40:0] m_cfg = '0;
   logic        m_qx = 1'b0, m_qy = 1'b0;

   always #5 clk = ~clk;

   clb5_logic_block uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_load(cfg_load),
      .cfg_sin (cfg_sin),
      .lin     (lin),
      .x_out   (x_out),
      .y_out   (y_out)
   );

   function automatic logic pick(input logic [1:0] s);
      case (s)
         2'd0:    return lin[3];
         2'd1:    return lin[4];
         2'd2:    return m_qx;
         default: return m_qy;
      endcase
   endfunction

   function automatic logic model_f();
      int idx;
      if (m_cfg[32]) idx = {pick(m_cfg[34:33]), lin[2:0]};
      else           idx = lin;
      return m_cfg[idx];
   endfunction

   function automatic logic model_g();
      int idx;
      if (m_cfg[32]) idx = 16 + {pick(m_cfg[36:35]), lin[2:0]};
      else           idx = lin;
      return m_cfg[idx];
   endfunction

   function automatic logic [40:0] mk(input logic [31:0] tbl, input bit split,
                                      input logic [1:0] fs, input logic [1:0] gs,
                                      input bit xg, input bit yg, input bit xr, input bit yr);
      return {yr, xr, yg, xg, gs, fs, split, tbl};
   endfunction

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Called just after a falling edge with inputs already driven.
   task automatic cycle(input string tag, output logic sx, output logic sy);
      logic f, g, ex, ey;
      #2;
      f  = model_f();
      g  = model_g();
      ex = (cfg_load || !rst_n) ? 1'b0 : (m_cfg[39] ? m_qx : f);
      ey = (cfg_load || !rst_n) ? 1'b0 : (m_cfg[40] ? m_qy : g);
      sx = x_out;
      sy = y_out;
      check_bit(tag, "x_out", x_out, ex);
      check_bit(tag, "y_out", y_out, ey);
      @(posedge clk);
      if (!rst_n) begin
         m_cfg = '0; m_qx = 0; m_qy = 0;
      end else if (cfg_load) begin
         m_cfg = {cfg_sin, m_cfg[40:1]};
         m_qx = 0; m_qy = 0;
      end else begin
         m_qx = m_cfg[37] ? g : f;
         m_qy = m_cfg[38] ? g : f;
      end
      @(negedge clk);
   endtask

   task automatic load_cfg(input logic [40:0] c);
      logic sx, sy;
      cfg_load = 1'b1;
      for (int i = 0; i < 41; i++) begin
         cfg_sin = c[i];
         cycle("R9", sx, sy);
      end
      cfg_load = 1'b0;
      cfg_sin  = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic sx, sy;
      logic [31:0] tbl;
      @(negedge clk);
      // R1: reset state across input patterns
      for (int i = 0; i < 4; i++) begin
         lin = 5'(i * 9);
         cycle("R1", sx, sy);
      end
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) begin
         lin = 5'(i);
         cycle("R1", sx, sy);
      end

      // R8: single entry 0 set; LSB-first placement
      load_cfg(mk(32'h1, 0, 0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 32; i++) begin
         lin = 5'(i);
         cycle("R8", sx, sy);
         check_bit("R8", "entry0 only", sx, (i == 0));
      end

      // R3: five-input AND
      load_cfg(mk(32'h8000_0000, 0, 0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 32; i++) begin
         lin = 5'(i);
         cycle("R3", sx, sy);
         check_bit("R3", "and5", sx, (i == 31));
         check_bit("R2", "g equals f", sy, sx);
      end

      // R2: arbitrary five-input functions
      for (int k = 0; k < 3; k++) begin
         tbl = $urandom;
         load_cfg(mk(tbl, 0, 0, 0, 0, 0, 0, 0));
         for (int i = 0; i < 32; i++) begin
            lin = 5'(i);
            cycle("R2", sx, sy);
            check_bit("R2", "table entry", sx, tbl[i]);
         end
      end

      // R4/R5: split mode over all select codes
      for (int fs = 0; fs < 4; fs++) begin
         for (int gs = 0; gs < 4; gs++) begin
            tbl = $urandom;
            load_cfg(mk(tbl, 1, 2'(fs), 2'(gs), gs[0], fs[0], 0, 0));
            for (int i = 0; i < 24; i++) begin
               lin = 5'($urandom);
               cycle(fs >= 2 || gs >= 2 ? "R5" : "R4", sx, sy);
            end
         end
      end

      // R5/R6/R7: toggle through X feedback, X registered
      load_cfg(mk(32'h0000_00FF, 1, 2'd2, 2'd0, 0, 0, 1, 0));
      for (int i = 0; i < 8; i++) begin
         lin = 5'($urandom);
         cycle("R5", sx, sy);
         check_bit("R5", "toggle", sx, 1'(i % 2));
      end
      // R9: load begins while flip-flop X holds 1 (i = 8 -> qx = 0, so step once)
      lin = 5'd0;
      cycle("R6", sx, sy);
      check_bit("R6", "qx before load", sx, 1'b0);
      // now qx = 1
      load_cfg(mk(32'h0000_00FF, 1, 2'd2, 2'd0, 0, 0, 1, 0));
      cycle("R9", sx, sy);
      check_bit("R9", "cleared by load", sx, 1'b0);

      // R6/R7: registered outputs with crossed sources, Y feedback
      for (int k = 0; k < 4; k++) begin
         tbl = $urandom;
         load_cfg(mk(tbl, k[0], 2'd3, 2'd2, k[1], ~k[1], 1, 1));
         for (int i = 0; i < 40; i++) begin
            lin = 5'($urandom);
            cycle("R6", sx, sy);
         end
      end
      // R7: mixed combinational / registered
      tbl = $urandom;
      load_cfg(mk(tbl, 1, 2'd1, 2'd3, 1, 0, 0, 1));
      for (int i = 0; i < 40; i++) begin
         lin = 5'($urandom);
         cycle("R7", sx, sy);
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule